// File: doc/BRIEF.md
# Shared Control and Status Register Block for a Multi-Channel DMA Engine

This block is the common register file that sits between a simple 32-bit register bus and up to twelve DMA channel engines. Software programs each channel's transfer mode (off, descriptor-chained, or single transfer) and its direction through packed 4-bit slots in two control words. It also sets a per-channel interrupt enable. The block sends these settings to the channel engines as plain wires.

In the other direction, every engine reports a live 2-bit activity code plus a one-cycle completion pulse and a one-cycle fault pulse. The block turns enabled pulses into sticky flags that software clears by writing 1s. It combines all the flags into one level-sensitive interrupt line. When software writes mode 0 into the slot of a channel that is not idle, the block sends a one-cycle abort strobe to that engine.

Reads are combinational: `bus_rdata` shows the word selected by `bus_addr` in the same cycle. Writes take effect at the next rising clock edge.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, all mode, direction and enable fields and all sticky flags are 0, `irq` and `ch_abort` are low, and every register offset reads 0 while all channels report idle.
- R2: Channel n (0 to 7) owns bits 4n+3..4n of the word at offset 0x00. Bits 1:0 hold the mode (0 off, 1 chained, 2 single; 3 is stored as written) and drive `ch_mode[2n+1:2n]`. Bit 2 is the direction (1 = memory to device) and drives `ch_dir[n]`. Bit 3 of each slot reads 0.
- R3: Channel n (8 to 11) owns the same 4-bit layout at bits 4(n-8)+3..4(n-8) of the word at offset 0x0C. Bits 31:16 of that word read 0 and ignore writes.
- R4: The enable word at offset 0x08 holds channel n's interrupt enable at bit n for n below 8 and at bit n+8 for n from 8 to 11, driving `ch_irq_en[n]`. All other bits read 0.
- R5: The status word at offset 0x10 shows the live `ch_state[2n+1:2n]` of channel n (0 to 7) at bits 17+2n..16+2n. The word at 0x18 shows it for channel n (8 to 11) at bits 17+2(n-8)..16+2(n-8).
- R6: A `ch_done[n]` pulse while the channel's enable is 1 sets its completion flag. A `ch_err[n]` pulse sets its fault flag in the same way. A pulse while the enable is 0 leaves the flags unchanged. In the status word that serves channel n (0x10 for n<8, 0x18 otherwise), with k = n mod 8, the completion flag is at bit k and the fault flag is at bit k+8.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it. Writes to the activity-code bits have no effect. If a set and a clear hit the same flag in one cycle, the flag ends up set.
- R8: `irq` is high exactly when at least one completion or fault flag is set. It rises in the cycle after the enabled pulse.
- R9: A write to a control word that puts mode 0 into channel n's slot while `ch_state[2n+1:2n]` is nonzero raises `ch_abort[n]` for the single cycle after the write. The same write to an idle channel raises no strobe.
- R10: Offsets 0x04, 0x14 and any offset not named above read 0, and writing to them changes no output and no readable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_mode | output | 2*NUM_CH | Per-channel transfer mode, 2 bits each |
| ch_dir | output | NUM_CH | Per-channel direction, 1 = memory to device |
| ch_irq_en | output | NUM_CH | Per-channel interrupt enable |
| ch_abort | output | NUM_CH | One-cycle abort strobe per channel |
| ch_state | input | 2*NUM_CH | Per-channel activity code: 0 idle, 1 fetching descriptor, 2 waiting on device, 3 moving data |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel fault pulse |
| irq | output | 1 | Level interrupt, OR of all sticky flags |

## Verification
The bench targets the split between the two control words. A design that folded channels 8 to 11 into the wrong word or nibble would move the wrong engine's mode. It also targets the enable word's gap at bits 8 to 15; a design that packed the upper enables contiguously would read back shifted.

It hits a flag with a set and a clear in the same cycle. A design where the clear wins would lose a completion event. It writes 1s over the activity-code bits, which a design that stored them would corrupt.

Abort strobes are provoked on a busy channel and deliberately withheld on an idle one in the same write. A design that strobed on every write of mode 0 would abort idle engines. A design that took the busy test from the wrong channel's code would miss the real abort.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int unsigned MAX_CH = 12;
  localparam int unsigned LO_CH  = 8;

  localparam logic [7:0] OFS_CTL_LO  = 8'h00;
  localparam logic [7:0] OFS_CTL_AUX = 8'h04;
  localparam logic [7:0] OFS_IEN     = 8'h08;
  localparam logic [7:0] OFS_CTL_HI  = 8'h0C;
  localparam logic [7:0] OFS_STS_LO  = 8'h10;
  localparam logic [7:0] OFS_STS_AUX = 8'h14;
  localparam logic [7:0] OFS_STS_HI  = 8'h18;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_CHAIN  = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  localparam logic [1:0] ACT_IDLE    = 2'd0;

  // Word holding the mode/direction slot of a channel
  function automatic logic [7:0] ctl_ofs(input int ch);
    return (ch < LO_CH) ? OFS_CTL_LO : OFS_CTL_HI;
  endfunction

  // Lowest bit of a channel's 4-bit slot inside its control word
  function automatic int ctl_lsb(input int ch);
    return 4 * (ch % LO_CH);
  endfunction

  // Position of the interrupt enable in the enable word
  function automatic int ien_bit(input int ch);
    return (ch < LO_CH) ? ch : ch + 8;
  endfunction

  // Status word serving a channel
  function automatic logic [7:0] sts_ofs(input int ch);
    return (ch < LO_CH) ? OFS_STS_LO : OFS_STS_HI;
  endfunction

  function automatic int done_bit(input int ch);
    return ch % LO_CH;
  endfunction

  function automatic int err_bit(input int ch);
    return (ch % LO_CH) + 8;
  endfunction

  function automatic int act_lsb(input int ch);
    return 16 + 2 * (ch % LO_CH);
  endfunction

endpackage

// File: rtl/dma_ch_ctl.sv
module dma_ch_ctl
  import dma_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_slot,
  input  logic [2:0] slot_wdata,
  input  logic       wr_ien,
  input  logic       ien_wbit,
  input  logic [1:0] act_code,
  output logic [1:0] mode,
  output logic       dir,
  output logic       ien,
  output logic       abort
);

  logic [1:0] new_mode;
  logic       abort_evt;

  assign new_mode  = slot_wdata[1:0];
  assign abort_evt = wr_slot && (new_mode == MODE_OFF) && (act_code != ACT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= MODE_OFF;
      dir   <= 1'b0;
      ien   <= 1'b0;
      abort <= 1'b0;
    end else begin
      if (wr_slot) begin
        mode <= new_mode;
        dir  <= slot_wdata[2];
      end
      if (wr_ien) ien <= ien_wbit;
      abort <= abort_evt;
    end
  end

  // R9: a strobe only follows a write that left the slot off
  a_r9_abort_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (mode == MODE_OFF));

  // R9: a strobe only follows a busy channel
  a_r9_abort_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($past(act_code) != ACT_IDLE));

endmodule

// File: rtl/dma_ch_flags.sv
module dma_ch_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic done_pulse,
  input  logic err_pulse,
  input  logic clr_done,
  input  logic clr_err,
  output logic done_flag,
  output logic err_flag
);

  logic set_done;
  logic set_err;

  assign set_done = done_pulse && ien;
  assign set_err  = err_pulse && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      done_flag <= set_done || (done_flag && !clr_done);
      err_flag  <= set_err  || (err_flag  && !clr_err);
    end
  end

  // R6: a flag only rises after an enabled pulse
  a_r6_done_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(done_pulse && ien));

  a_r6_err_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(err_pulse && ien));

  // R6: disabled channel cannot raise a clear flag
  a_r6_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !done_flag && !err_flag) |=> (!done_flag && !err_flag));

  // R7: a clear without a concurrent set empties the flag
  a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !set_done) |=> !done_flag);

endmodule

// File: rtl/dma_reg_rdmux.sv
module dma_reg_rdmux
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 12
) (
  input  logic [7:0]          addr,
  input  logic [2*NUM_CH-1:0] mode,
  input  logic [NUM_CH-1:0]   dir,
  input  logic [NUM_CH-1:0]   ien,
  input  logic [2*NUM_CH-1:0] act,
  input  logic [NUM_CH-1:0]   done_flag,
  input  logic [NUM_CH-1:0]   err_flag,
  output logic [31:0]         rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (addr == ctl_ofs(i)) begin
        rdata[ctl_lsb(i) +: 2] = mode[2*i +: 2];
        rdata[ctl_lsb(i) + 2]  = dir[i];
      end
      if (addr == OFS_IEN) rdata[ien_bit(i)] = ien[i];
      if (addr == sts_ofs(i)) begin
        rdata[done_bit(i)]     = done_flag[i];
        rdata[err_bit(i)]      = err_flag[i];
        rdata[act_lsb(i) +: 2] = act[2*i +: 2];
      end
    end
  end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [2*NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0]   ch_dir,
  output logic [NUM_CH-1:0]   ch_irq_en,
  output logic [NUM_CH-1:0]   ch_abort,
  input  logic [2*NUM_CH-1:0] ch_state,
  input  logic [NUM_CH-1:0]   ch_done,
  input  logic [NUM_CH-1:0]   ch_err,
  output logic                irq
);

  logic              wr_ien;
  logic [NUM_CH-1:0] wr_slot;
  logic [NUM_CH-1:0] wr_sts;
  logic [NUM_CH-1:0] done_flag;
  logic [NUM_CH-1:0] err_flag;
  logic              unused_wdata;

  assign wr_ien       = bus_we && (bus_addr == OFS_IEN);
  assign unused_wdata = ^bus_wdata;

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    assign wr_slot[g] = bus_we && (bus_addr == ctl_ofs(g));
    assign wr_sts[g]  = bus_we && (bus_addr == sts_ofs(g));

    dma_ch_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_slot    (wr_slot[g]),
      .slot_wdata (bus_wdata[ctl_lsb(g) +: 3]),
      .wr_ien     (wr_ien),
      .ien_wbit   (bus_wdata[ien_bit(g)]),
      .act_code   (ch_state[2*g +: 2]),
      .mode       (ch_mode[2*g +: 2]),
      .dir        (ch_dir[g]),
      .ien        (ch_irq_en[g]),
      .abort      (ch_abort[g])
    );

    dma_ch_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .ien        (ch_irq_en[g]),
      .done_pulse (ch_done[g]),
      .err_pulse  (ch_err[g]),
      .clr_done   (wr_sts[g] && bus_wdata[done_bit(g)]),
      .clr_err    (wr_sts[g] && bus_wdata[err_bit(g)]),
      .done_flag  (done_flag[g]),
      .err_flag   (err_flag[g])
    );
  end

  dma_reg_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .addr      (bus_addr),
    .mode      (ch_mode),
    .dir       (ch_dir),
    .ien       (ch_irq_en),
    .act       (ch_state),
    .done_flag (done_flag),
    .err_flag  (err_flag),
    .rdata     (bus_rdata)
  );

  assign irq = |{done_flag, err_flag};

  // R8: the line only rises after some enabled pulse
  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|((ch_done | ch_err) & ch_irq_en)));

  // R8: the line drops only on a status write
  a_r8_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|wr_sts));

  // R9: strobes appear only after a control write
  a_r9_abort_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_abort) |-> $past(|wr_slot));

endmodule

// File: tb/dma_ctl_regs_tb.sv
`timescale 1ns/1ps
module dma_ctl_regs_tb;

  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [2*N-1:0] ch_mode;
  logic [N-1:0]  ch_dir, ch_irq_en, ch_abort;
  logic [2*N-1:0] ch_state = '0;
  logic [N-1:0]  ch_done = '0, ch_err = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int m_mode[N];
  int m_dir[N];
  int m_en[N];
  int m_fd[N];
  int m_fe[N];
  logic [N-1:0] m_abort;

  always #2.5 clk = ~clk;

  dma_ctl_regs #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_mode(ch_mode),
    .ch_dir(ch_dir), .ch_irq_en(ch_irq_en), .ch_abort(ch_abort),
    .ch_state(ch_state), .ch_done(ch_done), .ch_err(ch_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int act_of(int n);
    return int'(ch_state[2*n +: 2]);
  endfunction

  // Expected word for an offset, assembled per offset from the model
  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] w = 0;
    case (a)
      8'h00: for (int n = 0; n < 8; n++)
               w |= 32'(m_mode[n] + 4 * m_dir[n]) << (4 * n);
      8'h0C: for (int n = 8; n < N; n++)
               w |= 32'(m_mode[n] + 4 * m_dir[n]) << (4 * (n - 8));
      8'h08: for (int n = 0; n < N; n++)
               if (m_en[n] != 0) w |= 32'd1 << (n < 8 ? n : n + 8);
      8'h10: for (int n = 0; n < 8; n++) begin
               if (m_fd[n] != 0) w |= 32'd1 << n;
               if (m_fe[n] != 0) w |= 32'd1 << (n + 8);
               w |= 32'(act_of(n)) << (16 + 2 * n);
             end
      8'h18: for (int n = 8; n < N; n++) begin
               if (m_fd[n] != 0) w |= 32'd1 << (n - 8);
               if (m_fe[n] != 0) w |= 32'd1 << n;
               w |= 32'(act_of(n)) << (16 + 2 * (n - 8));
             end
      default: w = 0;
    endcase
    return w;
  endfunction

  // One clock: drive, check read, advance model, check outputs
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                      input logic [N-1:0] dn, input logic [N-1:0] er, input string tag);
    logic [2*N-1:0] em;
    logic [N-1:0] ed, ee;
    int any;
    bus_addr = a; bus_we = we; bus_wdata = wd; ch_done = dn; ch_err = er;
    #1;
    chk({tag, " rdata"}, bus_rdata, model_read(a));
    m_abort = '0;
    for (int n = 0; n < N; n++) begin
      logic [7:0] so = (n < 8) ? 8'h10 : 8'h18;
      int k = n % 8;
      int cd = (we && a == so && wd[k]) ? 1 : 0;
      int ce = (we && a == so && wd[k + 8]) ? 1 : 0;
      m_fd[n] = ((m_fd[n] != 0 && cd == 0) || (dn[n] && m_en[n] != 0)) ? 1 : 0;
      m_fe[n] = ((m_fe[n] != 0 && ce == 0) || (er[n] && m_en[n] != 0)) ? 1 : 0;
    end
    for (int n = 0; n < N; n++) begin
      logic [7:0] co = (n < 8) ? 8'h00 : 8'h0C;
      if (we && a == co) begin
        int nib = int'((wd >> (4 * (n % 8))) & 32'h7);
        if ((nib % 4) == 0 && act_of(n) != 0) m_abort[n] = 1'b1;
        m_mode[n] = nib % 4;
        m_dir[n]  = nib / 4;
      end
      if (we && a == 8'h08) m_en[n] = wd[n < 8 ? n : n + 8] ? 1 : 0;
    end
    @(posedge clk); #1;
    em = '0; ed = '0; ee = '0; any = 0;
    for (int n = 0; n < N; n++) begin
      em[2*n +: 2] = 2'(m_mode[n]);
      ed[n] = m_dir[n][0];
      ee[n] = m_en[n][0];
      if (m_fd[n] != 0 || m_fe[n] != 0) any = 1;
    end
    chk({tag, " ch_mode"}, 32'(ch_mode), 32'(em));
    chk({tag, " ch_dir"}, 32'(ch_dir), 32'(ed));
    chk({tag, " ch_irq_en"}, 32'(ch_irq_en), 32'(ee));
    chk({tag, " ch_abort R9"}, 32'(ch_abort), 32'(m_abort));
    chk({tag, " irq R8"}, 32'(irq), 32'(any));
    @(negedge clk);
    bus_we = 1'b0; ch_done = '0; ch_err = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(a, 1'b0, 32'h0, '0, '0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, d, '0, '0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      m_mode[n] = 0; m_dir[n] = 0; m_en[n] = 0; m_fd[n] = 0; m_fe[n] = 0;
    end
    m_abort = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on every offset
    rd(8'h00, "R1 ctl lo"); rd(8'h08, "R1 ien"); rd(8'h0C, "R1 ctl hi");
    rd(8'h10, "R1 sts lo"); rd(8'h18, "R1 sts hi");

    // R2: lower control word, bit 3 of each slot masked
    wr(8'h00, 32'hFE96_2A51, "R2 write lo");
    rd(8'h00, "R2 readback lo");
    wr(8'h00, 32'h1234_5671, "R2 second pattern");
    rd(8'h00, "R2 readback 2");

    // R3: upper control word, bits 31:16 ignored
    wr(8'h0C, 32'hFFFF_5A16, "R3 write hi");
    rd(8'h0C, "R3 readback hi");
    rd(8'h00, "R3 lo untouched");

    // R4: enable word layout and gap
    wr(8'h08, 32'hFFFF_FFFF, "R4 all ones");
    rd(8'h08, "R4 readback ones");
    wr(8'h08, 32'h0005_00A5, "R4 pattern");
    rd(8'h08, "R4 readback pattern");

    // R5: live activity codes
    ch_state = 24'hE4_1B27;
    rd(8'h10, "R5 sts lo codes");
    rd(8'h18, "R5 sts hi codes");
    ch_state = 24'h00_0000;
    rd(8'h10, "R5 codes idle");

    // R6: enabled vs disabled pulses (enabled: 0,2,5,7,8,10)
    step(8'h10, 1'b0, 0, 12'b0101_0000_0110, 12'b0000_0000_0000, "R6 done mix");
    rd(8'h10, "R6 flags lo");
    step(8'h18, 1'b0, 0, 12'b0, 12'b1111_1010_0001, "R6 err mix");
    rd(8'h18, "R6 flags hi");
    rd(8'h10, "R6 flags lo err");

    // R7: partial W1C, activity bits ignore writes, set beats clear
    ch_state = 24'h55_AAAA;
    wr(8'h10, 32'hFFFF_0004, "R7 clear done2 only");
    rd(8'h10, "R7 after partial");
    step(8'h10, 1'b1, 32'h0000_0001, 12'h001, 12'h0, "R7 set and clear same cycle");
    rd(8'h10, "R7 set wins");
    wr(8'h18, 32'h0000_0000, "R7 zeros keep flags");
    rd(8'h18, "R7 hi kept");
    ch_state = 24'h0;

    // R8: clear everything, line must drop
    wr(8'h10, 32'h0000_FFFF, "R8 clear lo");
    wr(8'h18, 32'h0000_FFFF, "R8 clear hi");
    rd(8'h10, "R8 empty");
    step(8'h00, 1'b0, 0, 12'h400, 12'h0, "R8 single done ch10");
    wr(8'h18, 32'h0000_0004, "R8 clear ch10");

    // R9: abort on busy channel only
    wr(8'h00, 32'h0000_F222, "R9 arm lo");
    ch_state = 24'h00_00C0;
    wr(8'h00, 32'h0000_0022, "R9 off ch3 busy ch2 idle ch4");
    ch_state = 24'h08_0000;
    wr(8'h0C, 32'h0000_0001, "R9 off ch9 busy");
    ch_state = 24'h0;
    wr(8'h0C, 32'h0000_0000, "R9 off all idle");

    // R10: unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF, "R10 write 04");
    rd(8'h04, "R10 read 04");
    wr(8'h14, 32'hFFFF_FFFF, "R10 write 14");
    rd(8'h14, "R10 read 14");
    wr(8'h1C, 32'hFFFF_FFFF, "R10 write 1C");
    rd(8'h1C, "R10 read 1C");
    rd(8'h00, "R10 lo intact"); rd(8'h08, "R10 ien intact");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule